// File: doc/BRIEF.md
# Locked Software Command Front End

This block sits between a simple register port and the request/acknowledge port of a random bit generator. Software writes a 32-bit command word into a command register. The block forwards that word to the generator as a one-cycle request pulse. It then holds the interface busy until the generator returns an acknowledge. The acknowledge carries one error flag, which the block keeps as the completion status. Each completion also sets a sticky interrupt bit, and an enable mask gates that bit onto the interrupt output.

A configuration-open bit resets to 1. Writing 1 to it closes the configuration, and only a reset opens it again. While it is closed, writes to the control register and to the command register have no effect. A command is taken only when all four of these hold: the configuration is open, the control enable bit is set, the fuse-style enable input is high, and no earlier command is still waiting for its acknowledge.

Registers are at word indices, and `reg_addr` selects one. The read data is combinational and reflects the current state while `reg_re` is high.

Top module: `cmdfe_top`

## Requirements
- R1: The open bit (index 2, bit 0) reads 1 after reset. Writing 1 to it clears it. Once it is 0, no write returns it to 1; only reset does.
- R2: While the open bit is 0, writes to the control register (index 3) and to the command register (index 4) leave the state unchanged and start no command.
- R3: An accepted write to index 4 drives `cmd_valid` high for exactly the one cycle after the write edge, with `cmd_word` equal to the written data.
- R4: The ready flag (status index 5, bit 0) reads 1 after reset. It reads 0 from the acceptance edge until the edge on which `cmd_ack` is sampled. An acknowledge that arrives while ready is 1 changes nothing.
- R5: Status bit 1 takes the value of `cmd_err` at each accepted acknowledge: 0 means success and 1 means error. It keeps that value until the next accepted acknowledge.
- R6: A command write is accepted only when control bit 0 is 1 and `fuse_en` is high. Otherwise it is dropped.
- R7: A command write made while ready is 0 is dropped, and the outstanding `cmd_word` keeps its value.
- R8: The interrupt state bit (index 0, bit 0) is set by each accepted acknowledge and is cleared by writing 1 to it. When the set and the clear fall in the same cycle, the set wins.
- R9: `irq_done` equals the interrupt state bit ANDed with the interrupt enable bit (index 1, bit 0, reset 0).
- R10: The command register and unmapped indices read as 0, and `reg_rdata` is 0 while `reg_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | DATA_W | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Read data (combinational) |
| fuse_en | input | 1 | External enable for the software command path |
| cmd_valid | output | 1 | One-cycle command request qualifier |
| cmd_word | output | DATA_W | Command word of the current request |
| cmd_ack | input | 1 | Completion acknowledge from the generator |
| cmd_err | input | 1 | Error flag sampled with `cmd_ack` |
| irq_done | output | 1 | Masked command-done interrupt |

## Verification
Two events can land on the same clock edge: an acknowledge that sets the interrupt state bit, and a software write of 1 that clears it. The bench drives `cmd_ack` and the clearing write together for one cycle. It then reads the state bit and `irq_done` and expects both to be 1. A second overlap occurs when a command write meets a busy interface. The bench checks that such a write neither produces a pulse nor replaces the outstanding word.

// File: rtl/cmdfe_pkg.sv
package cmdfe_pkg;

    localparam int REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        IDX_INTR_STATE = 3'd0,
        IDX_INTR_EN    = 3'd1,
        IDX_OPEN       = 3'd2,
        IDX_CTRL       = 3'd3,
        IDX_CMD        = 3'd4,
        IDX_STATUS     = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic intr_state;
        logic intr_en;
        logic open;
        logic ctrl;
        logic cmd;
    } wr_sel_t;

    typedef struct packed {
        logic err;
        logic ready;
    } cmd_sts_t;

    function automatic wr_sel_t decode_write(logic [REG_IDX_W-1:0] idx, logic we);
        wr_sel_t s;
        s            = '0;
        s.intr_state = we && (idx == IDX_INTR_STATE);
        s.intr_en    = we && (idx == IDX_INTR_EN);
        s.open       = we && (idx == IDX_OPEN);
        s.ctrl       = we && (idx == IDX_CTRL);
        s.cmd        = we && (idx == IDX_CMD);
        return s;
    endfunction

endpackage

// File: rtl/cmdfe_regdec.sv
module cmdfe_regdec
    import cmdfe_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 we,
    output logic [REG_IDX_W-1:0] idx,
    output logic                 in_range,
    output wr_sel_t              wsel
);

    assign idx = addr[REG_IDX_W-1:0];

    generate
        if (ADDR_W > REG_IDX_W) begin : g_hi_bits
            assign in_range = (addr[ADDR_W-1:REG_IDX_W] == '0);
        end else begin : g_no_hi_bits
            assign in_range = 1'b1;
        end
    endgenerate

    assign wsel = decode_write(idx, we && in_range);

endmodule

// File: rtl/cmdfe_cfg.sv
module cmdfe_cfg (
    input  logic clk,
    input  logic rst,
    input  logic wr_open,
    input  logic wr_ctrl,
    input  logic wbit,
    output logic open,
    output logic ctrl_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            open    <= 1'b1;
            ctrl_en <= 1'b0;
        end else begin
            if (wr_open && wbit) open <= 1'b0;
            if (wr_ctrl && open) ctrl_en <= wbit;
        end
    end

    // R1: once closed, configuration stays closed until reset
    p_open_stays_closed_r1: assert property (@(posedge clk) disable iff (rst)
        !open |=> !open);

    // R2: control bit frozen while closed
    p_ctrl_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        !open |=> $stable(ctrl_en));

endmodule

// File: rtl/cmdfe_handshake.sv
module cmdfe_handshake
    import cmdfe_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic              path_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cmd_ack,
    input  logic              cmd_err,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_word,
    output cmd_sts_t          sts,
    output logic              done_evt
);

    logic accept;
    logic ready_q;
    logic err_q;

    assign accept   = cmd_wr && path_en && ready_q;
    assign done_evt = cmd_ack && !ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q   <= 1'b1;
            err_q     <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_word  <= '0;
        end else begin
            cmd_valid <= accept;
            if (accept) begin
                ready_q  <= 1'b0;
                cmd_word <= wdata;
            end else if (done_evt) begin
                ready_q <= 1'b1;
                err_q   <= cmd_err;
            end
        end
    end

    assign sts.ready = ready_q;
    assign sts.err   = err_q;

    // R3: request qualifier lasts a single cycle
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R4: a pulse is only seen while the interface is busy
    p_pulse_busy_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !ready_q);

    // R4: busy holds until acknowledge
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!ready_q && !cmd_ack) |=> !ready_q);

    // R4: acknowledge returns ready
    p_ack_ready_r4: assert property (@(posedge clk) disable iff (rst)
        (!ready_q && cmd_ack) |=> ready_q);

    // R5: status captures the error flag of the acknowledge
    p_err_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (!ready_q && cmd_ack) |=> (err_q == $past(cmd_err)));

    // R7: outstanding word not disturbed while busy
    p_word_held_r7: assert property (@(posedge clk) disable iff (rst)
        (!ready_q && !cmd_valid) |-> $stable(cmd_word));

endmodule

// File: rtl/cmdfe_irq.sv
module cmdfe_irq (
    input  logic clk,
    input  logic rst,
    input  logic done_evt,
    input  logic wr_state,
    input  logic wr_en,
    input  logic wbit,
    output logic state,
    output logic en,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= 1'b0;
            en    <= 1'b0;
        end else begin
            if (done_evt)               state <= 1'b1;
            else if (wr_state && wbit)  state <= 1'b0;
            if (wr_en) en <= wbit;
        end
    end

    assign irq = state && en;

    // R8: a completion always leaves the state bit set, even against a clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> state);

    // R8: write-one clears when no completion competes
    p_w1c_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_state && wbit && !done_evt) |=> !state);

endmodule

// File: rtl/cmdfe_top.sv
module cmdfe_top
    import cmdfe_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              fuse_en,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_word,
    input  logic              cmd_ack,
    input  logic              cmd_err,
    output logic              irq_done
);

    localparam int PAD_W = DATA_W - 2;

    logic [REG_IDX_W-1:0] idx;
    logic                 in_range;
    wr_sel_t              wsel;
    logic                 open;
    logic                 ctrl_en;
    logic                 path_en;
    cmd_sts_t             sts;
    logic                 done_evt;
    logic                 intr_state;
    logic                 intr_en;

    cmdfe_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (reg_addr),
        .we       (reg_we),
        .idx      (idx),
        .in_range (in_range),
        .wsel     (wsel)
    );

    cmdfe_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_open (wsel.open),
        .wr_ctrl (wsel.ctrl),
        .wbit    (reg_wdata[0]),
        .open    (open),
        .ctrl_en (ctrl_en)
    );

    assign path_en = ctrl_en && fuse_en;

    cmdfe_handshake #(.DATA_W(DATA_W)) u_hs (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (wsel.cmd && open),
        .path_en   (path_en),
        .wdata     (reg_wdata),
        .cmd_ack   (cmd_ack),
        .cmd_err   (cmd_err),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .sts       (sts),
        .done_evt  (done_evt)
    );

    cmdfe_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .done_evt (done_evt),
        .wr_state (wsel.intr_state),
        .wr_en    (wsel.intr_en),
        .wbit     (reg_wdata[0]),
        .state    (intr_state),
        .en       (intr_en),
        .irq      (irq_done)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_re && in_range) begin
            case (idx)
                IDX_INTR_STATE: reg_rdata = {{(DATA_W-1){1'b0}}, intr_state};
                IDX_INTR_EN:    reg_rdata = {{(DATA_W-1){1'b0}}, intr_en};
                IDX_OPEN:       reg_rdata = {{(DATA_W-1){1'b0}}, open};
                IDX_CTRL:       reg_rdata = {{(DATA_W-1){1'b0}}, ctrl_en};
                IDX_STATUS:     reg_rdata = {{PAD_W{1'b0}}, sts.err, sts.ready};
                default:        reg_rdata = '0;
            endcase
        end
    end

    // R6: no request leaves without the enable and the fuse input
    p_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (wsel.cmd && !path_en) |=> !cmd_valid);

    // R2: a closed configuration starts no command
    p_closed_no_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        (wsel.cmd && !open) |=> !cmd_valid);

endmodule

// File: tb/cmdfe_top_tb_top.sv
`timescale 1ns/1ps
module cmdfe_top_tb_top;

    localparam int AW = 4;
    localparam int DW = 32;
    localparam int NV = 46;

    localparam logic [3:0] KW = 4'd0; // write
    localparam logic [3:0] KR = 4'd1; // read and compare
    localparam logic [3:0] KA = 4'd2; // acknowledge, data[0] = error
    localparam logic [3:0] KC = 4'd3; // pulse count = exp, last word = data
    localparam logic [3:0] KI = 4'd4; // irq level = exp

    typedef struct packed {
        logic [3:0]    kind;
        logic [AW-1:0] addr;
        logic          fuse;
        logic [DW-1:0] data;
        logic [DW-1:0] exp;
    } vec_t;

    function automatic vec_t v(logic [3:0] k, logic [AW-1:0] a, logic f,
                               logic [DW-1:0] d, logic [DW-1:0] e);
        vec_t r;
        r.kind = k; r.addr = a; r.fuse = f; r.data = d; r.exp = e;
        return r;
    endfunction

    localparam vec_t VECS [NV] = '{
        v(KR, 4'd2, 1'b1, 32'h0, 32'h1),          // R1 open after reset
        v(KR, 4'd5, 1'b1, 32'h0, 32'h1),          // R4 ready after reset
        v(KR, 4'd3, 1'b1, 32'h0, 32'h0),
        v(KW, 4'd3, 1'b1, 32'h1, 32'h0),
        v(KR, 4'd3, 1'b1, 32'h0, 32'h1),
        v(KW, 4'd1, 1'b1, 32'h1, 32'h0),
        v(KW, 4'd4, 1'b1, 32'hA5A50001, 32'h0),   // R3
        v(KC, 4'd0, 1'b1, 32'hA5A50001, 32'd1),
        v(KR, 4'd5, 1'b1, 32'h0, 32'h0),          // R4 busy
        v(KW, 4'd4, 1'b1, 32'h00001111, 32'h0),   // R7 dropped
        v(KC, 4'd0, 1'b1, 32'hA5A50001, 32'd1),
        v(KA, 4'd0, 1'b1, 32'h1, 32'h0),          // R5 error
        v(KR, 4'd5, 1'b1, 32'h0, 32'h3),
        v(KR, 4'd0, 1'b1, 32'h0, 32'h1),          // R8
        v(KI, 4'd0, 1'b1, 32'h0, 32'h1),          // R9
        v(KW, 4'd0, 1'b1, 32'h1, 32'h0),
        v(KR, 4'd0, 1'b1, 32'h0, 32'h0),
        v(KI, 4'd0, 1'b1, 32'h0, 32'h0),
        v(KW, 4'd4, 1'b1, 32'h2, 32'h0),
        v(KA, 4'd0, 1'b1, 32'h0, 32'h0),          // R5 success
        v(KR, 4'd5, 1'b1, 32'h0, 32'h1),
        v(KC, 4'd0, 1'b1, 32'h2, 32'd2),
        v(KA, 4'd0, 1'b1, 32'h1, 32'h0),          // R4 spurious ack
        v(KR, 4'd5, 1'b1, 32'h0, 32'h1),
        v(KR, 4'd0, 1'b1, 32'h0, 32'h1),
        v(KW, 4'd1, 1'b1, 32'h0, 32'h0),
        v(KI, 4'd0, 1'b1, 32'h0, 32'h0),          // R9 masked
        v(KR, 4'd0, 1'b1, 32'h0, 32'h1),
        v(KW, 4'd3, 1'b1, 32'h0, 32'h0),
        v(KW, 4'd4, 1'b1, 32'h3, 32'h0),          // R6 enable off
        v(KC, 4'd0, 1'b1, 32'h2, 32'd2),
        v(KW, 4'd3, 1'b1, 32'h1, 32'h0),
        v(KW, 4'd4, 1'b0, 32'h4, 32'h0),          // R6 fuse low
        v(KC, 4'd0, 1'b1, 32'h2, 32'd2),
        v(KR, 4'd4, 1'b1, 32'h0, 32'h0),          // R10
        v(KR, 4'd7, 1'b1, 32'h0, 32'h0),          // R10
        v(KW, 4'd2, 1'b1, 32'h0, 32'h0),
        v(KR, 4'd2, 1'b1, 32'h0, 32'h1),          // R1 zero write
        v(KW, 4'd2, 1'b1, 32'h1, 32'h0),
        v(KR, 4'd2, 1'b1, 32'h0, 32'h0),          // R1 closed
        v(KW, 4'd3, 1'b1, 32'h0, 32'h0),
        v(KR, 4'd3, 1'b1, 32'h0, 32'h1),          // R2 ctrl frozen
        v(KW, 4'd4, 1'b1, 32'h5, 32'h0),
        v(KC, 4'd0, 1'b1, 32'h2, 32'd2),          // R2 no command
        v(KW, 4'd2, 1'b1, 32'h1, 32'h0),
        v(KR, 4'd2, 1'b1, 32'h0, 32'h0)           // R1 stays closed
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic          reg_re = 1'b0;
    logic [DW-1:0] reg_rdata;
    logic          fuse_en = 1'b1;
    logic          cmd_valid;
    logic [DW-1:0] cmd_word;
    logic          cmd_ack = 1'b0;
    logic          cmd_err = 1'b0;
    logic          irq_done;

    int n_vec = 0;
    int n_bad = 0;
    int pulses = 0;
    logic [DW-1:0] last_word = '0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    cmdfe_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .fuse_en(fuse_en), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_ack(cmd_ack), .cmd_err(cmd_err), .irq_done(irq_done)
    );

    always @(posedge clk) begin
        if (!rst && cmd_valid) begin
            pulses    = pulses + 1;
            last_word = cmd_word;
        end
    end

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, logic f);
        @(negedge clk);
        fuse_en = f; reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; fuse_en = 1'b1;
    endtask

    task automatic do_read(string req, logic [AW-1:0] a, logic [DW-1:0] e);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1;
        check(req, reg_rdata, e);
        reg_re = 1'b0;
    endtask

    task automatic do_ack(logic e);
        @(negedge clk);
        cmd_ack = 1'b1; cmd_err = e;
        @(negedge clk);
        cmd_ack = 1'b0; cmd_err = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        pulses = 0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state of outputs (R3, R9)
        check("R3 reset valid", {31'b0, cmd_valid}, 32'h0);
        check("R9 reset irq", {31'b0, irq_done}, 32'h0);
        check("R10 idle rdata", reg_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t t;
            t = VECS[i];
            case (t.kind)
                KW: do_write(t.addr, t.data, t.fuse);
                KR: do_read($sformatf("R10/vec%0d read", i), t.addr, t.exp);
                KA: do_ack(t.data[0]);
                KC: begin
                    @(negedge clk);
                    check($sformatf("R3 vec%0d count", i), pulses, t.exp);
                    check($sformatf("R7 vec%0d word", i), last_word, t.data);
                end
                default: begin
                    @(negedge clk);
                    check($sformatf("R9 vec%0d irq", i), {31'b0, irq_done}, t.exp);
                end
            endcase
        end

        // R1: reset reopens configuration
        do_reset();
        do_read("R1 reopened", 4'd2, 32'h1);

        // R3: exact pulse cycle and width
        do_write(4'd3, 32'h1, 1'b1);
        @(negedge clk);
        reg_addr = 4'd4; reg_wdata = 32'h77; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        check("R3 pulse high", {31'b0, cmd_valid}, 32'h1);
        check("R3 pulse word", cmd_word, 32'h77);
        @(negedge clk);
        check("R3 pulse low", {31'b0, cmd_valid}, 32'h0);

        // R8: completion and clear in the same cycle, set wins
        do_write(4'd1, 32'h1, 1'b1);
        @(negedge clk);
        cmd_ack = 1'b1; cmd_err = 1'b0;
        reg_addr = 4'd0; reg_wdata = 32'h1; reg_we = 1'b1;
        @(negedge clk);
        cmd_ack = 1'b0; reg_we = 1'b0;
        do_read("R8 set wins", 4'd0, 32'h1);
        check("R9 irq after collision", {31'b0, irq_done}, 32'h1);
        do_read("R4 ready after collision", 4'd5, 32'h1);

        finish_run();
    end

endmodule